// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is a bank of output cells. Each cell sits behind one sum term of a programmable logic array. For each cell, a two-bit configuration chooses between two modes. In registered mode, a D flip-flop captures the sum on the clock edge. In combinational mode, the sum passes straight through to the pin. The configuration also chooses the pin polarity. A per-cell enable term controls the pin driver. The cell returns a feedback bit to the array.

In registered mode the feedback is the raw flip-flop state, so the array can follow the state of a state machine. In combinational mode the feedback is the level on the pin. That level is the cell's own drive when the enable is high, or the external value when it is low. A cell whose enable is held low therefore acts as a plain input.

All flip-flops share three controls:
- a power-on clear;
- an asynchronous clear term;
- a preset term that takes effect only at a clock edge.

The pin is modelled as three separate signals: driven value, driver enable and sensed level.

Top module: `macrocell_bank`

## Requirements
- R1: Cell k takes its configuration from `cfg[2k+1:2k]`. Bit 2k+1 selects the mode: 0 is registered and 1 is combinational. Bit 2k selects the polarity: 1 is active-high (pin equals value) and 0 is active-low (pin is the inverse of the value).
- R2: In registered mode the flip-flop loads `sum_in[k]` at each rising clock edge. `pad_out[k]` shows the flip-flop state after the polarity of R1 is applied, and it changes only after that edge.
- R3: In registered mode `fb[k]` is the raw flip-flop state. It is independent of the polarity bit, `oe_term[k]` and `pad_in[k]`.
- R4: In combinational mode `pad_out[k]` is `sum_in[k]` after the polarity of R1 is applied, with no clock involved.
- R5: In combinational mode `fb[k]` equals `pad_out[k]` when `oe_term[k]` is 1, and equals `pad_in[k]` when it is 0.
- R6: `pad_oe[k]` follows `oe_term[k]` in every mode.
- R7: While `ar_term` is 1, every flip-flop reads 0 at once, without waiting for a clock edge. Clock edges during that time do not change this.
- R8: `sp_term` sets every flip-flop to 1 at the next rising edge. It has no effect between edges.
- R9: When `ar_term` and `sp_term` are both 1 at an edge, the flip-flops stay at 0.
- R10: While `por_n` is 0, every flip-flop is 0. A registered pin then reads 1 when active-low and 0 when active-high.
- R11: Each cell follows its own configuration, independently of its neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all flip-flops |
| por_n | input | 1 | Power-on clear, active low, asynchronous |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous preset term |
| cfg | input | 2*CELLS | Per-cell {mode, polarity} pairs |
| sum_in | input | CELLS | Sum-of-products input per cell |
| oe_term | input | CELLS | Driver enable term per cell |
| pad_in | input | CELLS | Level sensed on each pin |
| pad_out | output | CELLS | Value driven on each pin |
| pad_oe | output | CELLS | Driver enable for each pin |
| fb | output | CELLS | Feedback to the array per cell |

## Verification
The bench builds the bank with CELLS set to 4 and gives each cell a different one of the four configurations. Every stimulus vector therefore exercises both modes and both polarities side by side. Varying the enable and pin inputs per cell reaches the pin-as-input path and the registered feedback path in the same step. The directed part then swaps the cell-to-configuration mapping. It also drives the clear and preset terms mid-cycle and across edges to show their ordering.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic {
    MODE_REG  = 1'b0,
    MODE_COMB = 1'b1
  } cell_mode_e;

  // level placed on the pin for a value under a polarity choice
  function automatic logic apply_polarity(input logic value, input logic active_high);
    return active_high ? value : ~value;
  endfunction

  // what the array sees back from one cell
  function automatic logic pick_feedback(input cell_mode_e mode,
                                         input logic flop_q,
                                         input logic drive_en,
                                         input logic driven,
                                         input logic sensed);
    if (mode == MODE_REG) return flop_q;
    return drive_en ? driven : sensed;
  endfunction

endpackage

// File: rtl/mc_flop.sv
module mc_flop (
  input  logic clk,
  input  logic clr,
  input  logic preset,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk or posedge clr) begin
    if (clr)         q <= 1'b0;
    else if (preset) q <= 1'b1;
    else             q <= d;
  end

  AST_CLEAR_HOLDS: assert property (@(posedge clk) clr |-> !q); // R7
  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (clr)
    preset |=> q); // R8
  AST_LOADS_D: assert property (@(posedge clk) disable iff (clr)
    !preset |=> (q == $past(d))); // R2

endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       preset,
  input  logic [1:0] cfg,
  input  logic       sum,
  input  logic       oe,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       fb
);

  cell_mode_e mode;
  logic       active_high;
  logic       flop_q;
  logic       pre_pol;

  assign mode        = cell_mode_e'(cfg[1]);
  assign active_high = cfg[0];

  mc_flop u_flop (
    .clk    (clk),
    .clr    (clr),
    .preset (preset),
    .d      (sum),
    .q      (flop_q)
  );

  assign pre_pol = (mode == MODE_REG) ? flop_q : sum;
  assign pad_out = apply_polarity(pre_pol, active_high);
  assign pad_oe  = oe;
  assign fb      = pick_feedback(mode, flop_q, oe, pad_out, pad_in);

  AST_REG_POLARITY: assert property (@(posedge clk) disable iff (clr)
    (mode == MODE_REG) |-> (pad_out == (fb ^ ~active_high))); // R2
  AST_REG_FEEDBACK: assert property (@(posedge clk) disable iff (clr)
    ((mode == MODE_REG) && $stable(cfg) && !preset) |=> (fb == $past(sum))); // R3
  AST_COMB_DRIVEN_FB: assert property (@(posedge clk) disable iff (clr)
    ((mode == MODE_COMB) && oe && active_high) |-> (fb == sum)); // R5
  AST_COMB_INPUT_FB: assert property (@(posedge clk) disable iff (clr)
    ((mode == MODE_COMB) && !oe) |-> (fb == pad_in)); // R5

endmodule

// File: rtl/macrocell_bank.sv
module macrocell_bank #(
  parameter int CELLS = 10
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               ar_term,
  input  logic               sp_term,
  input  logic [2*CELLS-1:0] cfg,
  input  logic [CELLS-1:0]   sum_in,
  input  logic [CELLS-1:0]   oe_term,
  input  logic [CELLS-1:0]   pad_in,
  output logic [CELLS-1:0]   pad_out,
  output logic [CELLS-1:0]   pad_oe,
  output logic [CELLS-1:0]   fb
);

  localparam int CFG_W = 2;

  logic clr_any;
  assign clr_any = ~por_n | ar_term;

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    mc_cell u_cell (
      .clk     (clk),
      .clr     (clr_any),
      .preset  (sp_term),
      .cfg     (cfg[CFG_W*k +: CFG_W]),
      .sum     (sum_in[k]),
      .oe      (oe_term[k]),
      .pad_in  (pad_in[k]),
      .pad_out (pad_out[k]),
      .pad_oe  (pad_oe[k]),
      .fb      (fb[k])
    );
  end

  AST_OE_FOLLOWS: assert property (@(posedge clk) disable iff (!por_n)
    pad_oe == oe_term); // R6

endmodule

// File: tb/macrocell_bank_bench.sv
module macrocell_bank_bench;

  localparam int N = 4;
  localparam int NV = 8;
  // each entry: {sum, oe, pad_in}
  localparam logic [11:0] VEC [NV] = '{
    12'hF_F_0, 12'h0_F_F, 12'hA_5_3, 12'h5_0_F,
    12'h3_C_A, 12'hC_3_5, 12'h9_6_0, 12'h6_9_F
  };

  logic clk = 1'b0;
  logic por_n, ar_term, sp_term;
  logic [2*N-1:0] cfg;
  logic [N-1:0] sum_in, oe_term, pad_in, pad_out, pad_oe, fb;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  macrocell_bank #(.CELLS(N)) u_macrocell_bank (
    .clk(clk), .por_n(por_n), .ar_term(ar_term), .sp_term(sp_term),
    .cfg(cfg), .sum_in(sum_in), .oe_term(oe_term), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .fb(fb)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(20000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; ar_term = 1'b0; sp_term = 1'b0;
    cfg = 8'b11_10_01_00;             // cell0 reg/low, cell1 reg/high, cell2 comb/low, cell3 comb/high
    sum_in = '0; oe_term = '0; pad_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset pins", pad_out, 4'b0101);
    check("R10 reset feedback", fb, 4'b0000);
    check("R6 reset enables", pad_oe, 4'b0000);
    por_n = 1'b1;

    // table walk: after each edge, registered cells hold this vector's sum
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {sum_in, oe_term, pad_in} = VEC[v];
      @(posedge clk);
      #2;
      for (int k = 0; k < N; k++) begin
        logic comb, hi, lvl, efb;
        comb = cfg[2*k+1];
        hi   = cfg[2*k];
        lvl  = hi ? sum_in[k] : ~sum_in[k];   // same for both modes: flop now holds sum
        if (comb) efb = oe_term[k] ? lvl : pad_in[k];
        else      efb = sum_in[k];
        check1(comb ? "R4 comb pin" : "R2 reg pin", pad_out[k], lvl);
        check1(comb ? "R5 comb feedback" : "R3 reg feedback", fb[k], efb);
        check1("R6 enable", pad_oe[k], oe_term[k]);
      end
    end

    // R7: asynchronous clear between edges and across an edge
    @(negedge clk);
    sum_in = 4'hF; oe_term = 4'h0; pad_in = 4'h0;
    @(posedge clk); #2;
    check("R2 loaded ones", fb & 4'b0011, 4'b0011);
    #1 ar_term = 1'b1;
    #0.5;
    check("R7 clear before edge fb", fb & 4'b0011, 4'b0000);
    check("R7 clear before edge pin", pad_out & 4'b0011, 4'b0001);
    @(posedge clk); #2;
    check("R7 clear held over edge", fb & 4'b0011, 4'b0000);
    @(negedge clk);
    ar_term = 1'b0; sum_in = 4'h0;
    @(posedge clk); #2;

    // R8: preset waits for the edge
    @(negedge clk);
    sp_term = 1'b1;
    #1 check("R8 no effect before edge", fb & 4'b0011, 4'b0000);
    @(posedge clk); #2;
    check("R8 preset at edge fb", fb & 4'b0011, 4'b0011);
    check("R8 preset pins", pad_out, 4'b0110);

    // R9: clear beats preset
    @(negedge clk);
    ar_term = 1'b1;
    #1 check("R9 clear with preset", fb & 4'b0011, 4'b0000);
    @(posedge clk); #2;
    check("R9 both at edge", fb & 4'b0011, 4'b0000);
    @(negedge clk);
    ar_term = 1'b0;
    #1 check("R9 stays clear until edge", fb & 4'b0011, 4'b0000);
    @(posedge clk); #2;
    check("R8 preset after clear", fb & 4'b0011, 4'b0011);
    @(negedge clk);
    sp_term = 1'b0;

    // R11 / R1: remapped configuration
    cfg = 8'b00_01_10_11;             // cell0 comb/high, cell1 comb/low, cell2 reg/high, cell3 reg/low
    sum_in = 4'b0110; oe_term = 4'hF; pad_in = 4'h0;
    @(posedge clk); #2;
    check("R11 remapped pins", pad_out, 4'b1100);
    check("R1 remapped feedback", fb, 4'b0100);
    @(posedge clk); #2;
    check("R11 remapped stable", pad_out, 4'b1100);

    // R10: power-on clear mid-run
    @(negedge clk);
    por_n = 1'b0;
    #1;
    check("R10 mid-run clear pins", pad_out, 4'b1000);
    check("R10 mid-run clear feedback", fb, 4'b0000);
    @(negedge clk);
    por_n = 1'b1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule